// File: doc/BRIEF.md
# ADPCM Channel No-Operation Idle Output Controller

This block controls one channel of a serial-port speech transcoder while that channel is switched off. At each falling edge of the channel frame strobe it samples the channel enable. A low enable places the channel in a no-operation state. The block then spends a fixed number of system clocks saving the channel context, and shows this on a busy output. After that it waits for the next frame.

While the channel is in the no-operation state, the block drives two fixed idle patterns during each strobe-high window, one bit per rising edge of the serial bit clock. The compressed-side output sends an all-zero ADPCM code word. This word is 4 or 5 bits long, depending on the rate mode. The PCM-side output sends an 8-bit idle byte, and the companding-law select picks which byte. If the window holds more bit clocks than the word has bits, each pattern starts again from its first bit.

All inputs are sampled on the system clock. Each serial output register changes one system clock after the clock edge at which a bit-clock rise is seen.

Top module: `adpcm_nop_ctrl`

## Requirements
- R1: At every sampled falling edge of `frame_strobe`, `chan_nop` takes the inverse of `chan_en`. It is 1 (no-operation) from the next clock on and is unchanged at other times.
- R2: A sampled strobe fall with `chan_en` low raises `save_busy` on the next clock. `save_busy` stays high for exactly 4 clocks and then drops. A fall with `chan_en` high leaves it low.
- R3: `adpcm_sdo` carries an all-zero code word whose length is 4 bits for `rate_sel` 00, 01 and 10, and 5 bits for `rate_sel` 11. The output therefore stays 0 for any number of bit clocks.
- R4: The PCM idle byte is 8'b11111111 when `law_sel` is 1 (mu-law) and 8'b11010101 when `law_sel` is 0 (A-law).
- R5: The first bit-clock rise after the strobe goes high sends bit 7 (the sign bit), and the following rises send bits 6 down to 0. The ninth and later rises start again at bit 7.
- R6: While the strobe is high, the serial outputs change only one clock after a clock at which `bit_clk` is sampled rising. At all other times they hold.
- R7: Both serial outputs are 0 one clock after `frame_strobe` is sampled low, and they stay 0 whenever `chan_nop` is 0.
- R8: Asserting `rst_n` low clears `chan_nop`, `save_busy` and both serial outputs at once. Internal state stays cleared until the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_strobe | input | 1 | Channel frame strobe; its falling edge samples the enable |
| chan_en | input | 1 | Channel enable; low selects no-operation |
| bit_clk | input | 1 | Serial bit clock; its rising edges advance the patterns |
| rate_sel | input | 2 | Rate mode: 00 32k, 01 24k, 10 16k, 11 40k |
| law_sel | input | 1 | Companding law: 1 mu-law, 0 A-law |
| adpcm_sdo | output | 1 | Compressed-side serial idle output |
| pcm_sdo | output | 1 | PCM-side serial idle output |
| save_busy | output | 1 | High during the context save period |
| chan_nop | output | 1 | Channel is in the no-operation state |

## Verification
The assertions assume that `frame_strobe`, `bit_clk` and `chan_en` are synchronous to `clk`. They also assume that each level lasts at least one clock and that a new strobe fall never arrives while `save_busy` is still high. The stimulus meets these assumptions in three ways. It changes every input just after a falling clock edge. It holds each bit-clock level for two clocks. It keeps the strobe low for eight clocks after each fall. The assertions also assume that `rate_sel` and `law_sel` change only while the strobe is low, and the bench reprograms them only between frames.

// File: rtl/adpcm_nop_pkg.sv
package adpcm_nop_pkg;

  localparam int PCM_W      = 8;
  localparam int ADPCM_STDW = 4;
  localparam int ADPCM_MAXW = 5;
  localparam int SAVE_CYC   = 4;
  localparam int ALW        = $clog2(ADPCM_MAXW + 1);
  localparam int PLW        = $clog2(PCM_W + 1);

  typedef enum logic [1:0] {
    RATE_32K = 2'b00,
    RATE_24K = 2'b01,
    RATE_16K = 2'b10,
    RATE_40K = 2'b11
  } rate_e;

  typedef enum logic {
    LAW_A  = 1'b0,
    LAW_MU = 1'b1
  } law_e;

  typedef enum logic {
    SV_WAIT = 1'b0,
    SV_SAVE = 1'b1
  } save_st_e;

  // code word length selected by the rate mode
  function automatic logic [ALW-1:0] adpcm_len(input rate_e r);
    return (r == RATE_40K) ? ALW'(ADPCM_MAXW) : ALW'(ADPCM_STDW);
  endfunction

  // idle ADPCM word is all zero whatever its length
  function automatic logic [ADPCM_MAXW-1:0] adpcm_idle_word(input rate_e r);
    logic [ADPCM_MAXW-1:0] w;
    w = '0;
    if (r == RATE_40K) w = '0;
    return w;
  endfunction

  // PCM idle byte, sign bit in bit 7
  function automatic logic [PCM_W-1:0] pcm_idle_word(input law_e l);
    return (l == LAW_MU) ? 8'b1111_1111 : 8'b1101_0101;
  endfunction

endpackage

// File: rtl/adpcm_nop_rst_sync.sv
module adpcm_nop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_core_n = s2_q;
endmodule

// File: rtl/adpcm_nop_edge.sv
module adpcm_nop_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~q[i];
    assign fall[i] = ~din[i] & q[i];
  end
endmodule

// File: rtl/adpcm_nop_save_timer.sv
module adpcm_nop_save_timer
  import adpcm_nop_pkg::*;
#(
  parameter int CYC = 4,
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  save_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SV_WAIT: if (start) begin
        st_d  = SV_SAVE;
        cnt_d = CW'(CYC - 1);
      end
      SV_SAVE: begin
        if (cnt_q == '0) st_d = SV_WAIT;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SV_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SV_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q == SV_SAVE);
endmodule

// File: rtl/adpcm_nop_shifter.sv
module adpcm_nop_shifter #(
  parameter int MAXW = 8,
  localparam int LW = $clog2(MAXW + 1),
  localparam int IW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic            shift,
  input  logic [LW-1:0]   len,
  input  logic [MAXW-1:0] pattern,
  output logic            dout
);
  logic [IW-1:0] idx_q, idx_d, sel;
  logic          dout_q, dout_d;
  logic          last, upd;

  always_comb begin
    last   = (int'(idx_q) + 1) >= int'(len);
    sel    = IW'(int'(len) - 1 - int'(idx_q));
    idx_d  = idx_q;
    dout_d = dout_q;
    upd    = 1'b0;
    if (clear) begin
      idx_d  = '0;
      dout_d = 1'b0;
      upd    = 1'b1;
    end else if (run && shift) begin
      dout_d = pattern[sel];
      idx_d  = last ? '0 : idx_q + 1'b1;
      upd    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dout_q <= 1'b0;
    end else if (upd) begin
      idx_q  <= idx_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/adpcm_nop_ctrl.sv
module adpcm_nop_ctrl
  import adpcm_nop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_strobe,
  input  logic       chan_en,
  input  logic       bit_clk,
  input  logic [1:0] rate_sel,
  input  logic       law_sel,
  output logic       adpcm_sdo,
  output logic       pcm_sdo,
  output logic       save_busy,
  output logic       chan_nop
);
  localparam int SIG_N  = 2;
  localparam int SIG_FS = 0;
  localparam int SIG_BC = 1;

  logic             rst_core_n;
  logic [SIG_N-1:0] sig_rise, sig_fall;
  logic             fs_fall, bc_rise;
  logic             nop_q, nop_d;
  logic             lane_run, lane_clear;
  rate_e            rate;
  law_e             law;

  assign rate = rate_e'(rate_sel);
  assign law  = law_e'(law_sel);

  adpcm_nop_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_core_n(rst_core_n)
  );

  adpcm_nop_edge #(.N(SIG_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  ({bit_clk, frame_strobe}),
    .rise (sig_rise),
    .fall (sig_fall)
  );

  assign fs_fall = sig_fall[SIG_FS];
  assign bc_rise = sig_rise[SIG_BC];

  // no-operation flag: sampled only at strobe fall
  always_comb begin
    nop_d = nop_q;
    if (fs_fall) nop_d = ~chan_en;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  nop_q <= 1'b0;
    else if (fs_fall) nop_q <= nop_d;
  end

  adpcm_nop_save_timer #(.CYC(SAVE_CYC)) u_save (
    .clk  (clk),
    .rst_n(rst_core_n),
    .start(fs_fall & ~chan_en),
    .busy (save_busy)
  );

  assign lane_run   = nop_q & frame_strobe;
  assign lane_clear = ~frame_strobe;

  adpcm_nop_shifter #(.MAXW(ADPCM_MAXW)) u_tx_lane (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clear  (lane_clear),
    .run    (lane_run),
    .shift  (bc_rise),
    .len    (adpcm_len(rate)),
    .pattern(adpcm_idle_word(rate)),
    .dout   (adpcm_sdo)
  );

  adpcm_nop_shifter #(.MAXW(PCM_W)) u_rx_lane (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clear  (lane_clear),
    .run    (lane_run),
    .shift  (bc_rise),
    .len    (PLW'(PCM_W)),
    .pattern(pcm_idle_word(law)),
    .dout   (pcm_sdo)
  );

  assign chan_nop = nop_q;
endmodule

// File: rtl/adpcm_nop_ctrl_chk.sv
module adpcm_nop_ctrl_chk #(
  parameter int SAVE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic frame_strobe,
  input logic chan_en,
  input logic bit_clk,
  input logic adpcm_sdo,
  input logic pcm_sdo,
  input logic save_busy,
  input logic chan_nop
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_run <= 0;
    else if (save_busy) busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  AST_NOP_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_strobe) && !frame_strobe) |=> (chan_nop == !$past(chan_en))); // R1

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_strobe) && !frame_strobe && !chan_en && !save_busy) |=> save_busy); // R2

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_busy) |-> (busy_run == SAVE_CYC)); // R2

  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && $past(frame_strobe) && !(bit_clk && !$past(bit_clk)))
      |=> ($stable(pcm_sdo) && $stable(adpcm_sdo))); // R6

  AST_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> (!pcm_sdo && !adpcm_sdo)); // R7

  AST_LOW_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_nop |-> (!pcm_sdo && !adpcm_sdo)); // R7
endmodule

bind adpcm_nop_ctrl adpcm_nop_ctrl_chk #(.SAVE_CYC(SAVE_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .frame_strobe(frame_strobe),
  .chan_en     (chan_en),
  .bit_clk     (bit_clk),
  .adpcm_sdo   (adpcm_sdo),
  .pcm_sdo     (pcm_sdo),
  .save_busy   (save_busy),
  .chan_nop    (chan_nop)
);

// File: tb/adpcm_nop_ctrl_tb.sv
`timescale 1ns/1ps
module adpcm_nop_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic       chan_en = 1'b1;
  logic       bit_clk = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       law_sel = 1'b1;
  logic       adpcm_sdo, pcm_sdo, save_busy, chan_nop;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  adpcm_nop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .chan_en(chan_en),
    .bit_clk(bit_clk), .rate_sel(rate_sel), .law_sel(law_sel),
    .adpcm_sdo(adpcm_sdo), .pcm_sdo(pcm_sdo), .save_busy(save_busy), .chan_nop(chan_nop)
  );

  // behavioural reference model
  int m_rs = 0, m_busy_cnt = 0, m_pi = 0, m_ti = 0;
  bit m_inrst = 1'b1, m_prev_fs = 1'b0, m_prev_bc = 1'b0, m_nop = 1'b0;
  bit m_tx = 1'b0, m_rx = 1'b0;

  function automatic logic [7:0] idle_byte(input logic law);
    return law ? 8'hFF : 8'hD5; // R4
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_rs = 0;
    m_inrst = (m_rs < 2);
    if (rst_n && m_rs < 2) m_rs++;
    if (m_inrst) begin
      m_busy_cnt = 0; m_pi = 0; m_ti = 0;
      m_prev_fs = 0; m_prev_bc = 0; m_nop = 0; m_tx = 0; m_rx = 0;
    end else begin
      bit fs_fall, bc_rise;
      fs_fall = m_prev_fs && !frame_strobe;
      bc_rise = bit_clk && !m_prev_bc;
      if (fs_fall && !chan_en) m_busy_cnt = 4;
      else if (m_busy_cnt > 0) m_busy_cnt--;
      if (!frame_strobe) begin
        m_tx = 0; m_rx = 0; m_pi = 0; m_ti = 0;
      end else if (m_nop && bc_rise) begin
        logic [7:0] w;
        w = idle_byte(law_sel);
        m_rx = w[7 - m_pi];
        m_pi = (m_pi + 1) % 8;
        m_tx = 1'b0;
        m_ti = (m_ti + 1) % ((rate_sel == 2'b11) ? 5 : 4);
      end
      if (fs_fall) m_nop = !chan_en;
      m_prev_fs = frame_strobe;
      m_prev_bc = bit_clk;
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_byte(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      string rtag;
      rtag = m_inrst ? "R8" : (!m_prev_fs ? "R7" : "R5 R6");
      check_bit(m_inrst ? "R8" : "R1", chan_nop, m_nop);
      check_bit(m_inrst ? "R8" : "R2", save_busy, m_busy_cnt > 0);
      check_bit(m_inrst ? "R8" : "R3", adpcm_sdo, m_tx);
      check_bit(rtag, pcm_sdo, m_rx);
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  // one strobe-high window with n bit clocks; enable is set before the fall
  task automatic frame(input logic en_end, input int npulse, input logic [1:0] rate,
                       input logic law, output logic [15:0] cap_rx, output logic [15:0] cap_tx);
    cap_rx = '0;
    cap_tx = '0;
    rate_sel = rate;
    law_sel = law;
    step(1);
    frame_strobe = 1'b1;
    step(2);
    for (int p = 0; p < npulse; p++) begin
      bit_clk = 1'b1;
      @(negedge clk);
      if (p < 16) begin
        cap_rx[15 - p] = pcm_sdo;
        cap_tx[15 - p] = adpcm_sdo;
      end
      #2;
      step(1);
      bit_clk = 1'b0;
      step(2);
    end
    chan_en = en_end;
    step(1);
    frame_strobe = 1'b0;
    step(8);
  endtask

  initial begin
    logic [15:0] crx, ctx;
    @(posedge clk);
    started = 1'b1;
    step(3);
    // R8: outputs cleared during reset
    check_bit("R8", save_busy | chan_nop | pcm_sdo | adpcm_sdo, 1'b0);
    rst_n = 1'b1;
    step(4);

    // channel still enabled: nothing driven; request no-op at end (R1, R7)
    frame(1'b0, 8, 2'b00, 1'b1, crx, ctx);
    check_byte("R7", crx, 16'h0000);
    check_bit("R1", chan_nop, 1'b1);

    // mu-law, 32k, 8 bits (R4, R5)
    frame(1'b0, 8, 2'b00, 1'b1, crx, ctx);
    check_byte("R4", crx, {idle_byte(1'b1), 8'h00});
    check_byte("R3", ctx, 16'h0000);

    // A-law, 24k, 12 bits recirculate (R4, R5)
    frame(1'b0, 12, 2'b01, 1'b0, crx, ctx);
    check_byte("R5", crx, {idle_byte(1'b0), 8'hD0});

    // 40k mode, 11 bits: 5-bit zero word repeats (R3)
    frame(1'b0, 11, 2'b11, 1'b0, crx, ctx);
    check_byte("R3", ctx, 16'h0000);

    // 16k mode, mu-law, 16 bits, then re-enable at fall (R1)
    frame(1'b1, 16, 2'b10, 1'b1, crx, ctx);
    check_byte("R5", crx, 16'hFFFF);
    check_bit("R1", chan_nop, 1'b0);
    check_bit("R2", save_busy, 1'b0);

    // channel back on: outputs stay low (R7)
    frame(1'b0, 8, 2'b00, 1'b0, crx, ctx);
    check_byte("R7", crx, 16'h0000);

    // reset while no-op is active (R8)
    frame_strobe = 1'b1;
    step(2);
    bit_clk = 1'b1;
    step(2);
    bit_clk = 1'b0;
    frame_strobe = 1'b0;
    step(1);
    rst_n = 1'b0;
    step(2);
    check_bit("R8", chan_nop | save_busy | pcm_sdo, 1'b0);
    rst_n = 1'b1;
    step(4);
    frame(1'b1, 8, 2'b00, 1'b1, crx, ctx);
    check_byte("R8", crx, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule